// File: doc/BRIEF.md
# Ethernet Receive Framing FIFO

This block sits between a receive MAC and a host. Received frames arrive one byte per cycle on a valid/ready/last stream. Each frame is written into a byte-addressed circular store as one self-describing record. A record starts with a fixed marker word and a header word that gives the stored length and a good-status code. The payload follows, zero-filled up to the 60-byte Ethernet minimum if it is shorter. Next comes the Ethernet CRC-32 of the filled payload, and then zero bytes up to the next 4-byte boundary. The CRC is computed on the fly, one byte per cycle.

The host unloads records through one 32-bit data register. A small unload sequencer steps through the marker, the header and the body words. It uses the header length to find where each record ends. A frame-count register reports how many complete records are waiting, and writing zero to it discards them all. A status flag is raised when a record is completed, and it drives the interrupt line through an enable mask.

The host port is a plain register strobe interface with a 3-bit address. Read data appears on `reg_rdata` one clock after the read strobe. Address 0 is control, with bit 0 as the receive enable. Address 1 is the data register, address 2 the frame count, address 3 the interrupt enable (bit 0) and address 4 the interrupt status (bit 0). Any other address reads as zero.

Top module: `ethrx_frame_fifo`

## Requirements
- R1: After reset, `in_ready` and `irq` are low, the frame count reads 0, and a data register read returns 0.
- R2: A frame is taken up only when `in_valid` is high, the receive enable is set and at least READY_FREE (1532) bytes are free. `in_ready` stays low while the 4 marker bytes are written, so the first payload byte is accepted 5 cycles after `in_valid` is first seen in the idle state. `in_ready` is low again from the cycle after the last byte until the record is complete.
- R3: A record's first word is MAGIC (default 32'hE7A1_5C3D). Its second word has the stored length (filled payload length + 4) in bits 15:0 and OK_CODE (default 16'h0001) in bits 31:16.
- R4: A payload shorter than 60 bytes is followed by zero bytes up to 60 bytes.
- R5: After the filled payload comes the CRC-32 over the filled payload: reflected polynomial 32'hEDB88320, start value all ones, final value complemented, least significant byte first.
- R6: Zero bytes follow the CRC up to the next 4-byte boundary, so every record is a whole number of words.
- R7: Bytes are packed into words little-endian: the earliest byte of each group of four sits in bits 7:0.
- R8: Data register reads return the marker, then the header, then ceil(length/4) body words. After the last body word the next read returns the next record's marker, and the frame count drops by one.
- R9: A data register read while the frame count is 0 returns 0 and consumes nothing.
- R10: Writing 0 to the frame-count register discards all complete records, zeroes the count and restarts the unload sequence at a marker. Writing a nonzero value to it has no effect.
- R11: Completing a record sets status bit 0. Writing a 1 to status bit 0 clears it. `irq` is high exactly when status bit 0 and enable bit 0 are both set.
- R12: While fewer than READY_FREE bytes are free, a waiting frame is held off with `in_ready` low. It is taken up once the host drains enough records.
- R13: With the receive enable clear, no frame is started and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Ingress byte accepted when high with in_valid |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| irq | output | 1 | Receive interrupt |

## Verification
The situation that is hardest to reach from the ports is the space threshold. The store must hold enough data that fewer than 1532 bytes are free while a further frame is already waiting. The stimulus stores a 500-byte frame and then a 60-byte frame. It presents a third frame and watches `in_ready` stay low, drains the first record through the data register, and then sees the waiting frame accepted and stored intact. A second awkward case is a discard issued partway through unloading a record. Here the bench reads a few words of one record, writes zero to the count, and checks that the next record is unloaded from its marker.

// File: rtl/erf_pkg.sv
package erf_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_DATA  = 3'd1;
  localparam logic [2:0] A_FCNT  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_ISTAT = 3'd4;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [2:0] {W_IDLE, W_MAGIC, W_DATA, W_PAD, W_CRC, W_ALIGN, W_HDR} wr_st_e;
  typedef enum logic [1:0] {R_MAGIC, R_HDR, R_DATA} rd_st_e;

  // one byte of reflected CRC-32, lowest bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    x = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ CRC_POLY) : (x >> 1);
    return x;
  endfunction

  function automatic logic [7:0] lane(input logic [31:0] w, input logic [1:0] i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [15:0] round4(input logic [15:0] v);
    return (v + 16'd3) & 16'hFFFC;
  endfunction
endpackage

// File: rtl/erf_mem.sv
module erf_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wbyte,
  input  logic [AW-3:0] rword_idx,
  output logic [31:0]   rword
);
  localparam int WORDS = 1 << (AW - 2);

  logic [3:0][7:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr[AW-1:2]][waddr[1:0]] <= wbyte;
  end

  assign rword = store[rword_idx];
endmodule

// File: rtl/erf_writer.sv
module erf_writer import erf_pkg::*; #(
  parameter int          AW         = 11,
  parameter int          READY_FREE = 1532,
  parameter int          MIN_LEN    = 60,
  parameter logic [31:0] MAGIC      = 32'hE7A1_5C3D,
  parameter logic [15:0] OK_CODE    = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW:0]   free_bytes,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_byte,
  output logic          commit,
  output logic [AW:0]   cwp
);
  wr_st_e      st;
  logic [AW:0] wp, base;
  logic [15:0] cnt;
  logic [1:0]  idx;
  logic [31:0] crc;
  logic [31:0] hdr_word;
  logic        start_ok;

  assign hdr_word = {OK_CODE, cnt + 16'd4};
  assign start_ok = in_valid && rx_en && (free_bytes >= (AW+1)'(READY_FREE));
  assign in_ready = (st == W_DATA);
  assign commit   = (st == W_HDR) && (idx == 2'd3);

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wp[AW-1:0];
    wr_byte = 8'd0;
    case (st)
      W_MAGIC: begin
        wr_en   = 1'b1;
        wr_addr = base[AW-1:0] + AW'(idx);
        wr_byte = lane(MAGIC, idx);
      end
      W_DATA:  begin wr_en = in_valid; wr_byte = in_data; end
      W_PAD:   wr_en = 1'b1;
      W_CRC:   begin wr_en = 1'b1; wr_byte = lane(~crc, idx); end
      W_ALIGN: wr_en = 1'b1;
      W_HDR: begin
        wr_en   = 1'b1;
        wr_addr = base[AW-1:0] + AW'(4) + AW'(idx);
        wr_byte = lane(hdr_word, idx);
      end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      wp   <= '0;
      base <= '0;
      cwp  <= '0;
      cnt  <= '0;
      idx  <= '0;
      crc  <= '1;
    end else begin
      case (st)
        W_IDLE: if (start_ok) begin
          base <= wp;
          idx  <= 2'd0;
          st   <= W_MAGIC;
        end
        W_MAGIC: begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            wp  <= base + (AW+1)'(8);
            cnt <= '0;
            crc <= '1;
            st  <= W_DATA;
          end
        end
        W_DATA: if (in_valid) begin
          wp  <= wp + 1'b1;
          cnt <= cnt + 16'd1;
          crc <= crc_step(crc, in_data);
          if (in_last) begin
            idx <= 2'd0;
            st  <= (cnt + 16'd1 < 16'(MIN_LEN)) ? W_PAD : W_CRC;
          end
        end
        W_PAD: begin
          wp  <= wp + 1'b1;
          cnt <= cnt + 16'd1;
          crc <= crc_step(crc, 8'd0);
          if (cnt + 16'd1 == 16'(MIN_LEN)) st <= W_CRC;
        end
        W_CRC: begin
          wp  <= wp + 1'b1;
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= (cnt[1:0] == 2'd0) ? W_HDR : W_ALIGN;
        end
        W_ALIGN: begin
          wp <= wp + 1'b1;
          if (wp[1:0] == 2'b11) st <= W_HDR;
        end
        W_HDR: begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            cwp <= wp;
            st  <= W_IDLE;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R6
  rec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wp[1:0] == 2'b00));
  // R13
  no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_IDLE) && !rx_en |=> !in_ready);
endmodule

// File: rtl/erf_unload.sv
module erf_unload import erf_pkg::*; #(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pop,
  input  logic        flush,
  input  logic [AW:0] flush_ptr,
  input  logic [15:0] hdr_len,
  output logic [AW:0] rp,
  output logic        frame_done
);
  rd_st_e      st;
  logic [15:0] remain;

  assign frame_done = pop && !flush && (st == R_DATA) && (remain == 16'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_MAGIC;
      rp     <= '0;
      remain <= '0;
    end else if (flush) begin
      st     <= R_MAGIC;
      rp     <= flush_ptr;
      remain <= '0;
    end else if (pop) begin
      rp <= rp + (AW+1)'(4);
      case (st)
        R_MAGIC: st <= R_HDR;
        R_HDR: begin
          remain <= round4(hdr_len);
          st     <= R_DATA;
        end
        R_DATA: begin
          remain <= remain - 16'd4;
          if (remain == 16'd4) st <= R_MAGIC;
        end
        default: st <= R_MAGIC;
      endcase
    end
  end

  // R8
  hdr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush && (st == R_HDR) |=> (remain != 16'd0) && (remain[1:0] == 2'b00));
endmodule

// File: rtl/ethrx_frame_fifo.sv
module ethrx_frame_fifo import erf_pkg::*; #(
  parameter int          DEPTH      = 2048,
  parameter int          READY_FREE = 1532,
  parameter int          MIN_LEN    = 60,
  parameter logic [31:0] MAGIC      = 32'hE7A1_5C3D,
  parameter logic [15:0] OK_CODE    = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);

  logic          rx_en, int_en, int_stat;
  logic [AW:0]   fcount, rp, cwp, used, free_bytes;
  logic          wr_en, commit, frame_done;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_byte;
  logic [31:0]   rword;
  logic          rd_data, pop, flush, stat_clr;

  assign used       = cwp - rp;
  assign free_bytes = (AW+1)'(DEPTH) - used;
  assign rd_data    = reg_rd && (reg_addr == A_DATA);
  assign pop        = rd_data && (fcount != '0);
  assign flush      = reg_wr && (reg_addr == A_FCNT) && (reg_wdata == 32'd0);
  assign stat_clr   = reg_wr && (reg_addr == A_ISTAT) && reg_wdata[0];
  assign irq        = int_stat && int_en;

  erf_writer #(.AW(AW), .READY_FREE(READY_FREE), .MIN_LEN(MIN_LEN),
               .MAGIC(MAGIC), .OK_CODE(OK_CODE)) u_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .free_bytes(free_bytes),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .commit(commit), .cwp(cwp));

  erf_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wbyte(wr_byte),
    .rword_idx(rp[AW-1:2]), .rword(rword));

  erf_unload #(.AW(AW)) u_unload (
    .clk(clk), .rst_n(rst_n), .pop(pop), .flush(flush), .flush_ptr(cwp),
    .hdr_len(rword[15:0]), .rp(rp), .frame_done(frame_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= 1'b0;
      int_en    <= 1'b0;
      int_stat  <= 1'b0;
      fcount    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) rx_en  <= reg_wdata[0];
      if (reg_wr && reg_addr == A_IEN)  int_en <= reg_wdata[0];
      int_stat <= commit | (int_stat & ~stat_clr);
      if (flush) fcount <= (AW+1)'(commit);
      else       fcount <= fcount + (AW+1)'(commit) - (AW+1)'(frame_done);
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= {31'd0, rx_en};
          A_DATA:  reg_rdata <= pop ? rword : 32'd0;
          A_FCNT:  reg_rdata <= 32'(fcount);
          A_IEN:   reg_rdata <= {31'd0, int_en};
          A_ISTAT: reg_rdata <= {31'd0, int_stat};
          default: reg_rdata <= 32'd0;
        endcase
      end
    end
  end

  // R9
  empty_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && (fcount == '0) && !flush |=> $stable(rp));
  // R10
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !commit |=> (fcount == '0));
  // R11
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> int_stat);
  // R12
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));
endmodule

// File: tb/ethrx_frame_fifo_tb.sv
`timescale 1ns/1ps
module ethrx_frame_fifo_tb;
  localparam logic [31:0] MAGIC_W = 32'hE7A1_5C3D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  ethrx_frame_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // driver: builds the expected record words, then streams the payload
  task automatic send_frame(input int n, input int seed, input bit chk_start);
    logic [7:0]  pay[$];
    logic [7:0]  rec[$];
    logic [31:0] c = 32'hFFFF_FFFF;
    int plen, stall, i;
    for (int j = 0; j < n; j++) pay.push_back(8'(seed * 37 + j * 13 + 5));
    plen = (n < 60) ? 60 : n;
    for (int j = 0; j < plen; j++) begin
      logic [7:0] b = (j < n) ? pay[j] : 8'd0;
      rec.push_back(b);
      c = ref_crc(c, b);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) rec.push_back(c[8*k +: 8]);
    while (rec.size() % 4 != 0) rec.push_back(8'd0);
    exp_q.push_back(MAGIC_W);
    exp_q.push_back({16'h0001, 16'(plen + 4)});
    for (int w = 0; w < rec.size() / 4; w++)
      exp_q.push_back({rec[4*w+3], rec[4*w+2], rec[4*w+1], rec[4*w]});
    i = 0; stall = 0;
    while (i < n) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pay[i]; in_last = (i == n - 1);
      if (in_ready) i++;
      else if (i == 0) stall++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (chk_start) begin
      chk("R2 first byte accepted 5 cycles after valid", 32'(stall), 32'd5);
      chk("R2 ready low after last byte", {31'd0, in_ready}, 32'd0);
    end
  endtask

  // monitor: unloads one record and compares it with the scoreboard
  task automatic unload_frame(input string tag);
    logic [31:0] d, e;
    int nw;
    reg_read(3'd1, d);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
    chk({"R3 R8 marker ", tag}, d, e);
    reg_read(3'd1, d);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
    chk({"R3 header ", tag}, d, e);
    nw = (int'(d[15:0]) + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      reg_read(3'd1, d);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
      chk({"R4 R5 R6 R7 body ", tag}, d, e);
    end
  endtask

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, in_ready}, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    reg_read(3'd2, d); chk("R1 count after reset", d, 32'd0);
    reg_read(3'd1, d); chk("R1 R9 empty data read", d, 32'd0);

    // R13: receive disabled, a waiting frame is never started
    in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
    hi = 0;
    repeat (12) begin @(negedge clk); if (in_ready) hi++; end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R13 ready stays low when disabled", 32'(hi), 32'd0);
    reg_read(3'd2, d); chk("R13 nothing stored", d, 32'd0);

    reg_write(3'd0, 32'd1);
    send_frame(20, 1, 1'b1);
    repeat (80) @(negedge clk);
    reg_read(3'd4, d); chk("R11 status set", d, 32'd1);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    reg_write(3'd3, 32'd1);
    chk("R11 irq enabled", {31'd0, irq}, 32'd1);
    reg_read(3'd2, d); chk("R10 count one", d, 32'd1);
    unload_frame("short");
    reg_read(3'd2, d); chk("R8 count after unload", d, 32'd0);
    reg_read(3'd1, d); chk("R9 drained read", d, 32'd0);
    reg_write(3'd4, 32'd1);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    reg_read(3'd4, d); chk("R11 status cleared", d, 32'd0);

    send_frame(61, 2, 1'b1); repeat (80) @(negedge clk); unload_frame("len61");
    send_frame(64, 3, 1'b1); repeat (80) @(negedge clk); unload_frame("len64");
    send_frame(1, 4, 1'b1);  repeat (80) @(negedge clk); unload_frame("len1");

    send_frame(30, 5, 1'b1); repeat (80) @(negedge clk);
    send_frame(70, 6, 1'b1); repeat (80) @(negedge clk);
    reg_read(3'd2, d); chk("R8 two stored", d, 32'd2);
    unload_frame("pairA"); unload_frame("pairB");

    // R12: fill past the threshold, hold a third frame, then drain
    send_frame(500, 7, 1'b1); repeat (80) @(negedge clk);
    send_frame(60, 8, 1'b1);  repeat (80) @(negedge clk);
    fork
      send_frame(100, 9, 1'b0);
      begin
        hi = 0;
        repeat (60) begin @(negedge clk); if (in_ready) hi++; end
        chk("R12 held off while full", 32'(hi), 32'd0);
        reg_read(3'd2, d); chk("R12 count while held", d, 32'd2);
        unload_frame("big");
      end
    join
    repeat (80) @(negedge clk);
    reg_read(3'd2, d); chk("R12 held frame stored", d, 32'd2);
    unload_frame("after_big"); unload_frame("released");

    // R10: discard part way through a record
    send_frame(20, 10, 1'b1); repeat (80) @(negedge clk);
    send_frame(20, 11, 1'b1); repeat (80) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      reg_read(3'd1, d);
      chk("R8 partial read", d, exp_q.pop_front());
    end
    reg_write(3'd2, 32'd7);
    reg_read(3'd2, d); chk("R10 nonzero write ignored", d, 32'd2);
    reg_write(3'd2, 32'd0);
    exp_q.delete();
    reg_read(3'd2, d); chk("R10 count flushed", d, 32'd0);
    reg_read(3'd1, d); chk("R10 R9 read after flush", d, 32'd0);
    send_frame(45, 12, 1'b1); repeat (80) @(negedge clk);
    unload_frame("post_flush");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule